// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block turns the short file-register operand of a small banked microcontroller into a full data memory address. It also performs the read or write at that address in a 4K x 8 data RAM. The operand is 8 bits and the data space is 12 bits wide. The upper four address bits come from one of three places: a bank register, a fixed low or top page, or a movable window pointer. Which one applies depends on an access-select bit and an extended-mode enable.

With extended mode off, the unbanked path splits the operand space in half. The lower half lands at the bottom of memory and the upper half lands in the last 128 bytes. With extended mode on, operands up to 5Fh are added to a 12-bit window pointer, modulo 4096. Operands from 60h upward land in the top page at F60h to FFFh. The banked path ignores extended mode entirely.

The bank and pointer registers are loaded through two simple write ports. The computed address is driven out, so a surrounding core or a bench can observe it.

Top module: `bank_addr_mapper`

## Requirements
- R1: After reset, the window pointer and the bank register both hold zero. So with acc_sel=1 and opnd=00h the address is 000h, and with ext_en=1, acc_sel=0 and opnd=05h the address is 005h.
- R2: When acc_sel=1, eff_addr = {bank[3:0], opnd[7:0]}, whether ext_en is 0 or 1.
- R3: When acc_sel=0 and ext_en=0, operands 00h–7Fh give eff_addr = 000h–07Fh, and operands 80h–FFh give F80h–FFFh. That is, F00h + opnd.
- R4: When acc_sel=0, ext_en=1 and opnd ≤ 5Fh, eff_addr = pointer + opnd. With the pointer at 120h, opnd 00h gives 120h and opnd 5Fh gives 17Fh.
- R5: When acc_sel=0, ext_en=1 and opnd is 60h–FFh, eff_addr = F00h + opnd. So 60h gives F60h and FFh gives FFFh.
- R6: A pointer or bank load (ptr_we or bank_we high at a rising edge) is first used for mapping in the cycle after that edge. Without a load, the register holds its value.
- R7: A write with ram_we=1 stores ram_wdata at eff_addr on the rising edge. ram_rdata shows the byte at the current eff_addr combinationally. Locations 000h–05Fh, which the window hides in extended mode, stay reachable and keep separate contents through acc_sel=1 with bank 0.
- R8: The window sum wraps modulo 4096. With the pointer at FC0h, opnd 5Fh gives 01Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_we | input | 1 | Load enable for the window pointer |
| ptr_wdata | input | 12 | New window pointer value |
| bank_we | input | 1 | Load enable for the bank register |
| bank_wdata | input | 4 | New bank value |
| ext_en | input | 1 | Extended (window) mode enable |
| acc_sel | input | 1 | 1 = banked addressing, 0 = unbanked path |
| opnd | input | 8 | File-register operand |
| ram_we | input | 1 | RAM write enable |
| ram_wdata | input | 8 | RAM write data |
| eff_addr | output | 12 | Computed data memory address |
| ram_rdata | output | 8 | RAM read data at eff_addr |

## Verification
The bench builds the block at its default sizes: a 12-bit address, an 8-bit operand and a 96-byte window. At these sizes every operand value in both modes can be swept exhaustively, including the 5Fh/60h window edge and the 7Fh/80h split. A pointer near FFFh brings the modulo-4096 wrap within reach in a few cycles. Random traffic mixes register loads with RAM writes. This exposes the one-cycle load latency and aliasing between the window and bank 0.

// File: rtl/bam_pkg.sv
package bam_pkg;
  typedef enum logic [1:0] {
    SRC_BANKED  = 2'd0,
    SRC_LOWPAGE = 2'd1,
    SRC_TOPPAGE = 2'd2,
    SRC_WINDOW  = 2'd3
  } addr_src_e;
endpackage

// File: rtl/bam_rst_sync.sv
module bam_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/bam_ldreg.sv
module bam_ldreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/bam_map.sv
module bam_map
  import bam_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int OPND_W   = 8,
  parameter int WIN_SPAN = 96,
  localparam int BANK_W  = ADDR_W - OPND_W
) (
  input  logic              acc_sel,
  input  logic              ext_en,
  input  logic [OPND_W-1:0] opnd,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output addr_src_e         src
);
  localparam logic [OPND_W-1:0] WIN_LIM = OPND_W'(WIN_SPAN);

  logic in_win;
  logic in_low;

  assign in_win = (opnd < WIN_LIM);
  assign in_low = ~opnd[OPND_W-1];

  always_comb begin
    if (acc_sel)     src = SRC_BANKED;
    else if (ext_en) src = in_win ? SRC_WINDOW : SRC_TOPPAGE;
    else             src = in_low ? SRC_LOWPAGE : SRC_TOPPAGE;
  end

  always_comb begin
    unique case (src)
      SRC_BANKED:  addr = {bank, opnd};
      SRC_LOWPAGE: addr = {{BANK_W{1'b0}}, opnd};
      SRC_TOPPAGE: addr = {{BANK_W{1'b1}}, opnd};
      default:     addr = ptr + {{BANK_W{1'b0}}, opnd};
    endcase
  end
endmodule

// File: rtl/bam_ram.sv
module bam_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/bank_addr_mapper.sv
module bank_addr_mapper
  import bam_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int OPND_W   = 8,
  parameter int DATA_W   = 8,
  parameter int WIN_SPAN = 96,
  localparam int BANK_W  = ADDR_W - OPND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_we,
  input  logic [ADDR_W-1:0] ptr_wdata,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              ext_en,
  input  logic              acc_sel,
  input  logic [OPND_W-1:0] opnd,
  input  logic              ram_we,
  input  logic [DATA_W-1:0] ram_wdata,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [DATA_W-1:0] ram_rdata
);
  logic              rst_q_n;
  logic [ADDR_W-1:0] ptr_q;
  logic [BANK_W-1:0] bank_q;
  addr_src_e         src;

  bam_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  bam_ldreg #(.W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_q_n), .ld(ptr_we), .d(ptr_wdata), .q(ptr_q)
  );

  bam_ldreg #(.W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .ld(bank_we), .d(bank_wdata), .q(bank_q)
  );

  bam_map #(.ADDR_W(ADDR_W), .OPND_W(OPND_W), .WIN_SPAN(WIN_SPAN)) u_map (
    .acc_sel(acc_sel), .ext_en(ext_en), .opnd(opnd),
    .ptr(ptr_q), .bank(bank_q), .addr(eff_addr), .src(src)
  );

  bam_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(eff_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );
endmodule

// File: rtl/bam_chk.sv
module bam_chk
  import bam_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int OPND_W   = 8,
  parameter int DATA_W   = 8,
  parameter int WIN_SPAN = 96,
  localparam int BANK_W  = ADDR_W - OPND_W
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              ptr_we,
  input logic [ADDR_W-1:0] ptr_wdata,
  input logic              bank_we,
  input logic [BANK_W-1:0] bank_wdata,
  input logic              ext_en,
  input logic              acc_sel,
  input logic [OPND_W-1:0] opnd,
  input logic              ram_we,
  input logic [DATA_W-1:0] ram_wdata,
  input logic [ADDR_W-1:0] eff_addr,
  input logic [DATA_W-1:0] ram_rdata,
  input logic [ADDR_W-1:0] ptr_q,
  input logic [BANK_W-1:0] bank_q,
  input addr_src_e         src
);
  // R2
  banked_addr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    acc_sel |-> (eff_addr[ADDR_W-1:OPND_W] == bank_q && eff_addr[OPND_W-1:0] == opnd));

  // R3
  split_high_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!acc_sel && !ext_en && opnd[OPND_W-1]) |-> (&eff_addr[ADDR_W-1:OPND_W]));

  // R4
  window_sum_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!acc_sel && ext_en && opnd < OPND_W'(WIN_SPAN)) |->
      (src == SRC_WINDOW && eff_addr == ADDR_W'(ptr_q + ADDR_W'(opnd))));

  // R5
  ext_top_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!acc_sel && ext_en && opnd >= OPND_W'(WIN_SPAN)) |->
      (&eff_addr[ADDR_W-1:OPND_W] && eff_addr[OPND_W-1:0] == opnd));

  // R6
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ptr_we |=> ptr_q == $past(ptr_wdata));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ptr_we |=> $stable(ptr_q));

  // R6
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    bank_we |=> bank_q == $past(bank_wdata));

  // R7
  ram_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(ram_we) && eff_addr == $past(eff_addr)) |-> ram_rdata == $past(ram_wdata));
endmodule

bind bank_addr_mapper bam_chk #(
  .ADDR_W(ADDR_W), .OPND_W(OPND_W), .DATA_W(DATA_W), .WIN_SPAN(WIN_SPAN)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
  .bank_we(bank_we), .bank_wdata(bank_wdata), .ext_en(ext_en),
  .acc_sel(acc_sel), .opnd(opnd), .ram_we(ram_we), .ram_wdata(ram_wdata),
  .eff_addr(eff_addr), .ram_rdata(ram_rdata), .ptr_q(ptr_q),
  .bank_q(bank_q), .src(src)
);

// File: tb/sim_bank_addr_mapper.sv
`timescale 1ns/1ps
module sim_bank_addr_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ptr_we, bank_we, ext_en, acc_sel, ram_we;
  logic [11:0] ptr_wdata;
  logic [3:0]  bank_wdata;
  logic [7:0]  opnd, ram_wdata;
  logic [11:0] eff_addr;
  logic [7:0]  ram_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_ptr = 0;
  int m_bank = 0;
  logic [7:0] m_mem [int];

  always #4 clk = ~clk;

  bank_addr_mapper u0 (
    .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .bank_we(bank_we), .bank_wdata(bank_wdata), .ext_en(ext_en),
    .acc_sel(acc_sel), .opnd(opnd), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .eff_addr(eff_addr), .ram_rdata(ram_rdata)
  );

  function automatic int ref_addr(bit acc, bit ext, int op);
    if (acc) return m_bank * 256 + op;
    if (ext && op < 96) return (m_ptr + op) % 4096;
    if (!ext && op < 128) return op;
    return 'hF00 + op;
  endfunction

  function automatic string auto_tag(bit acc, bit ext, int op);
    if (acc) return "R2";
    if (!ext) return "R3";
    if (op >= 96) return "R5";
    if (m_ptr + op >= 4096) return "R8";
    return "R4";
  endfunction

  task automatic step(string tg, bit acc, bit ext, logic [7:0] op,
                      bit pwe, logic [11:0] pd, bit bwe, logic [3:0] bd,
                      bit rwe, logic [7:0] rd);
    int exp;
    string t;
    @(negedge clk);
    acc_sel = acc; ext_en = ext; opnd = op;
    ptr_we = pwe; ptr_wdata = pd; bank_we = bwe; bank_wdata = bd;
    ram_we = rwe; ram_wdata = rd;
    #1;
    exp = ref_addr(acc, ext, int'(op));
    t = (tg != "") ? tg : ((pwe || bwe) ? "R6" : auto_tag(acc, ext, int'(op)));
    checks++;
    if (int'(eff_addr) != exp) begin
      errors++;
      $display("FAIL %s eff_addr act=%03h exp=%03h", t, eff_addr, exp[11:0]);
    end
    if (m_mem.exists(exp)) begin
      checks++;
      if (ram_rdata !== m_mem[exp]) begin
        errors++;
        $display("FAIL R7 ram_rdata act=%02h exp=%02h @%03h", ram_rdata, m_mem[exp], exp[11:0]);
      end
    end
    @(posedge clk);
    if (pwe) m_ptr = int'(pd);
    if (bwe) m_bank = int'(bd);
    if (rwe) m_mem[exp] = rd;
  endtask

  task automatic load_ptr(logic [11:0] v);
    step("R6", 1'b1, 1'b0, 8'h00, 1'b1, v, 1'b0, 4'h0, 1'b0, 8'h00);
  endtask

  task automatic load_bank(logic [3:0] v);
    step("R6", 1'b1, 1'b0, 8'h00, 1'b0, 12'h000, 1'b1, v, 1'b0, 8'h00);
  endtask

  task automatic look(bit acc, bit ext, logic [7:0] op);
    step("", acc, ext, op, 1'b0, 12'h000, 1'b0, 4'h0, 1'b0, 8'h00);
  endtask

  task automatic wr(bit acc, bit ext, logic [7:0] op, logic [7:0] d);
    step("R7", acc, ext, op, 1'b0, 12'h000, 1'b0, 4'h0, 1'b1, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ptr_we = 0; bank_we = 0; ext_en = 0; acc_sel = 0; ram_we = 0;
    ptr_wdata = '0; bank_wdata = '0; opnd = '0; ram_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: registers at zero after reset
    step("R1", 1'b1, 1'b0, 8'h00, 1'b0, 12'h0, 1'b0, 4'h0, 1'b0, 8'h00);
    step("R1", 1'b0, 1'b1, 8'h05, 1'b0, 12'h0, 1'b0, 4'h0, 1'b0, 8'h00);

    // R3: full sweep, extended mode off
    for (int i = 0; i < 256; i++) look(1'b0, 1'b0, 8'(i));

    // R6: load takes effect one cycle later
    load_bank(4'h3);
    look(1'b1, 1'b0, 8'h44);
    // R2: banked, both modes
    for (int i = 0; i < 256; i += 7) begin
      look(1'b1, 1'b0, 8'(i));
      look(1'b1, 1'b1, 8'(i));
    end

    // R4 / R5: window at 120h
    load_ptr(12'h120);
    look(1'b0, 1'b1, 8'h00);
    look(1'b0, 1'b1, 8'h5F);
    look(1'b0, 1'b1, 8'h60);
    look(1'b0, 1'b1, 8'hFF);
    for (int i = 0; i < 256; i++) look(1'b0, 1'b1, 8'(i));

    // R7: window and bank 0 keep separate contents
    wr(1'b0, 1'b1, 8'h10, 8'hAA);
    load_bank(4'h1);
    look(1'b1, 1'b0, 8'h30);
    load_bank(4'h0);
    wr(1'b1, 1'b1, 8'h10, 8'h55);
    look(1'b0, 1'b1, 8'h10);
    look(1'b1, 1'b1, 8'h10);

    // R8: wrap near the top of memory
    load_ptr(12'hFC0);
    look(1'b0, 1'b1, 8'h3F);
    look(1'b0, 1'b1, 8'h40);
    look(1'b0, 1'b1, 8'h5F);

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("", r[0], r[1], 8'(r[15:8]), (r[19:16] == 0), 12'($urandom),
           (r[23:20] == 0), 4'($urandom), r[24] & r[25], 8'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule